// File: doc/BRIEF.md
# Instruction Cache Configuration and Invalidation Register Block

This block holds the software-visible settings of an instruction cache and turns them into control signals. A single-cycle configuration bus writes and reads five registers: the cache size selection, the freeze enable, a global invalidation trigger, a block invalidation base address and a block invalidation word count. The block drives three outputs from them: the active cache capacity, the scratch SRAM capacity, and a freeze flag. The scratch SRAM is whatever part of the fixed on-chip storage the cache does not use.

Invalidation goes out as a stream of requests toward the tag store, one per clock. A global sweep visits every tag index of the full storage. A block walk visits every cache line that holds part of a word range, starting at the base address. A size change that software makes while the block is running starts a global sweep without any further write. A global trigger always wins over a block walk that is in progress.

Top module: `icache_cfg_regs`

## Requirements
- R1: After reset every register reads 0, `cache_kb` is 0, `sram_kb` equals the total storage (32), `freeze_en` is 0 and `inv_valid` is 0.
- R2: Register offsets are: 0 size code (bits 2:0), 1 freeze (bit 0), 2 invalidation control (bit 0 global active, bit 1 busy), 3 base byte address, 4 word count (bits 15:0). Size code 0/1/2/3/4 gives `cache_kb` 0/4/8/16/32, and `sram_kb` is always 32 minus `cache_kb`.
- R3: A write of size code 5, 6 or 7 is ignored: the size register and `cache_kb` keep their values and no sweep starts.
- R4: `freeze_en` follows bit 0 of the last write to offset 1, and that bit reads back at offset 1.
- R5: A legal size write that differs from the current code starts a global sweep, and its first request shows in the cycle after the write. A write of the same code starts nothing.
- R6: A write with bit 0 set to offset 2 starts a global sweep. The sweep issues one request per cycle for indices 0 to 1023 in order, with `inv_global`=1. While it runs, offset 2 reads 3, and it reads 0 once the sweep is over.
- R7: A nonzero count write to offset 4 while idle starts a block walk. The walk issues lines floor(base/32) to floor((base+4*count-1)/32) in order, one per cycle, with `inv_global`=0. During the walk, offset 2 reads 2. A count of 0 starts no walk.
- R8: A global trigger during a block walk abandons the walk, and one during a sweep restarts it. In both cases the next cycle shows global index 0.
- R9: A count write while an invalidation is in progress is ignored: the register keeps its value and no walk follows. Base writes are always accepted.
- R10: Reads of offsets 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 3 | Register offset for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| cache_kb | output | 6 | Active cache capacity in KB |
| sram_kb | output | 6 | Storage left as scratch SRAM in KB |
| freeze_en | output | 1 | Freeze mode flag |
| inv_valid | output | 1 | Invalidation request this cycle |
| inv_global | output | 1 | Request belongs to a global sweep (line is a tag index) |
| inv_line | output | 27 | Tag index (sweep) or line address (block walk) |

## Verification
The bench builds the block with its defaults: 32 KB total, a 4 KB smallest cache, 32-byte lines, 4-byte words and a 16-bit word count. These give a 1024-entry sweep, so the bench can follow every sweep request by request, including the restarted and the superseding ones. With these sizes, small random base addresses and counts reach walks of one line, walks that cross a line boundary, and multi-line walks. Random size codes, reserved ones among them, reach both the repeated-code case and the size-change-triggered sweep many times.

// File: rtl/icache_cfg_pkg.sv
package icache_cfg_pkg;

  typedef enum logic [1:0] {
    INV_IDLE   = 2'd0,
    INV_GLOBAL = 2'd1,
    INV_BLOCK  = 2'd2
  } inv_mode_e;

  localparam logic [2:0] OFS_SIZE   = 3'd0;
  localparam logic [2:0] OFS_FREEZE = 3'd1;
  localparam logic [2:0] OFS_GINV   = 3'd2;
  localparam logic [2:0] OFS_BASE   = 3'd3;
  localparam logic [2:0] OFS_COUNT  = 3'd4;

endpackage

// File: rtl/icache_size_map.sv
module icache_size_map #(
  parameter int TOTAL_KB = 32,
  parameter int MIN_KB   = 4,
  parameter int CODE_W   = 3,
  parameter int KB_W     = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o,
  output logic [KB_W-1:0]   cache_kb_o,
  output logic [KB_W-1:0]   sram_kb_o
);
  localparam int MAX_CODE = $clog2(TOTAL_KB / MIN_KB) + 1;

  always_comb begin
    legal_o = (int'(code_i) <= MAX_CODE);
    if (code_i == '0 || !legal_o) begin
      cache_kb_o = '0;
    end else begin
      cache_kb_o = KB_W'(MIN_KB) << (code_i - CODE_W'(1));
    end
    sram_kb_o = KB_W'(TOTAL_KB) - cache_kb_o;
  end

endmodule

// File: rtl/icache_cfg_regfile.sv
module icache_cfg_regfile
  import icache_cfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wcode_legal_i,
  input  logic              busy_i,
  input  logic              glob_active_i,
  output logic [CODE_W-1:0] size_q_o,
  output logic              freeze_q_o,
  output logic [ADDR_W-1:0] base_q_o,
  output logic [CNT_W-1:0]  wcount_o,
  output logic              glob_trig_o,
  output logic              blk_trig_o,
  output logic [31:0]       rdata_o
);
  logic [CODE_W-1:0] size_q, size_d;
  logic              freeze_q, freeze_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              size_en, freeze_en_w, base_en, count_en;
  logic [CODE_W-1:0] wcode;

  assign wcode    = wdata_i[CODE_W-1:0];
  assign wcount_o = wdata_i[CNT_W-1:0];

  always_comb begin
    size_en     = wr_en_i && addr_i == OFS_SIZE && wcode_legal_i && wcode != size_q;
    freeze_en_w = wr_en_i && addr_i == OFS_FREEZE;
    base_en     = wr_en_i && addr_i == OFS_BASE;
    count_en    = wr_en_i && addr_i == OFS_COUNT && !busy_i;
    glob_trig_o = size_en || (wr_en_i && addr_i == OFS_GINV && wdata_i[0]);
    blk_trig_o  = count_en && wcount_o != '0;
    size_d      = size_en     ? wcode      : size_q;
    freeze_d    = freeze_en_w ? wdata_i[0] : freeze_q;
    base_d      = base_en     ? wdata_i[ADDR_W-1:0] : base_q;
    count_d     = count_en    ? wcount_o   : count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= '0;
      freeze_q <= 1'b0;
      base_q   <= '0;
      count_q  <= '0;
    end else begin
      size_q   <= size_d;
      freeze_q <= freeze_d;
      base_q   <= base_d;
      count_q  <= count_d;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_SIZE:   rdata_o = 32'(size_q);
      OFS_FREEZE: rdata_o = 32'(freeze_q);
      OFS_GINV:   rdata_o = {30'd0, busy_i, glob_active_i};
      OFS_BASE:   rdata_o = 32'(base_q);
      OFS_COUNT:  rdata_o = 32'(count_q);
      default:    rdata_o = '0;
    endcase
  end

  assign size_q_o   = size_q;
  assign freeze_q_o = freeze_q;
  assign base_q_o   = base_q;

endmodule

// File: rtl/icache_inv_seq.sv
module icache_inv_seq
  import icache_cfg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int SETS       = 1024
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  glob_trig_i,
  input  logic                                  blk_trig_i,
  input  logic [ADDR_W-1:0]                     base_i,
  input  logic [CNT_W-1:0]                      count_i,
  output logic                                  busy_o,
  output logic                                  glob_active_o,
  output logic                                  inv_valid_o,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  inv_line_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSH    = $clog2(WORD_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam logic [LINE_W-1:0] LAST_SET = LINE_W'(SETS - 1);

  inv_mode_e         mode_q, mode_d;
  logic [LINE_W-1:0] cur_q, cur_d;
  logic [LINE_W-1:0] last_q, last_d;
  logic [ADDR_W:0]   end_addr;
  logic [LINE_W-1:0] blk_first, blk_last;

  always_comb begin
    end_addr  = {1'b0, base_i} + ((ADDR_W+1)'(count_i) << WSH) - (ADDR_W+1)'(1);
    blk_first = base_i[ADDR_W-1:OFF_W];
    blk_last  = end_addr[ADDR_W] ? '1 : end_addr[ADDR_W-1:OFF_W];
  end

  always_comb begin
    mode_d = mode_q;
    cur_d  = cur_q;
    last_d = last_q;
    if (glob_trig_i) begin
      mode_d = INV_GLOBAL;
      cur_d  = '0;
    end else if (blk_trig_i && mode_q == INV_IDLE) begin
      mode_d = INV_BLOCK;
      cur_d  = blk_first;
      last_d = blk_last;
    end else if (mode_q == INV_GLOBAL) begin
      if (cur_q == LAST_SET) mode_d = INV_IDLE;
      else                   cur_d  = cur_q + LINE_W'(1);
    end else if (mode_q == INV_BLOCK) begin
      if (cur_q == last_q) mode_d = INV_IDLE;
      else                 cur_d  = cur_q + LINE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= INV_IDLE;
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      mode_q <= mode_d;
      cur_q  <= cur_d;
      last_q <= last_d;
    end
  end

  assign busy_o        = mode_q != INV_IDLE;
  assign glob_active_o = mode_q == INV_GLOBAL;
  assign inv_valid_o   = busy_o;
  assign inv_line_o    = cur_q;

endmodule

// File: rtl/icache_cfg_regs.sv
module icache_cfg_regs #(
  parameter int TOTAL_KB   = 32,
  parameter int MIN_KB     = 4,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_wr_en,
  input  logic [2:0]                            cfg_addr,
  input  logic [31:0]                           cfg_wdata,
  output logic [31:0]                           cfg_rdata,
  output logic [$clog2(TOTAL_KB+1)-1:0]         cache_kb,
  output logic [$clog2(TOTAL_KB+1)-1:0]         sram_kb,
  output logic                                  freeze_en,
  output logic                                  inv_valid,
  output logic                                  inv_global,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  inv_line
);
  localparam int KB_W     = $clog2(TOTAL_KB + 1);
  localparam int MAX_CODE = $clog2(TOTAL_KB / MIN_KB) + 1;
  localparam int CODE_W   = $clog2(MAX_CODE + 1);
  localparam int SETS     = (TOTAL_KB * 1024) / LINE_BYTES;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [CODE_W-1:0] size_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  wcount;
  logic              wcode_legal, cur_legal;
  logic [KB_W-1:0]   wcode_kb, wcode_sram;
  logic              glob_trig, blk_trig, busy, glob_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  icache_size_map #(.TOTAL_KB(TOTAL_KB), .MIN_KB(MIN_KB), .CODE_W(CODE_W), .KB_W(KB_W))
    u_wmap (.code_i(cfg_wdata[CODE_W-1:0]), .legal_o(wcode_legal),
            .cache_kb_o(wcode_kb), .sram_kb_o(wcode_sram));

  icache_size_map #(.TOTAL_KB(TOTAL_KB), .MIN_KB(MIN_KB), .CODE_W(CODE_W), .KB_W(KB_W))
    u_cmap (.code_i(size_q), .legal_o(cur_legal),
            .cache_kb_o(cache_kb), .sram_kb_o(sram_kb));

  icache_cfg_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en_i(cfg_wr_en), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .wcode_legal_i(wcode_legal), .busy_i(busy),
    .glob_active_i(glob_active), .size_q_o(size_q), .freeze_q_o(freeze_en),
    .base_q_o(base_q), .wcount_o(wcount), .glob_trig_o(glob_trig),
    .blk_trig_o(blk_trig), .rdata_o(cfg_rdata)
  );

  icache_inv_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES),
                   .WORD_BYTES(WORD_BYTES), .SETS(SETS)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .glob_trig_i(glob_trig), .blk_trig_i(blk_trig),
    .base_i(base_q), .count_i(wcount), .busy_o(busy), .glob_active_o(glob_active),
    .inv_valid_o(inv_valid), .inv_line_o(inv_line)
  );

  assign inv_global = glob_active;

endmodule

// File: rtl/icache_cfg_checker.sv
module icache_cfg_checker #(
  parameter int TOTAL_KB = 32,
  parameter int MIN_KB   = 4,
  parameter int KB_W     = 6,
  parameter int LINE_W   = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [2:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic [KB_W-1:0]   cache_kb,
  input logic [KB_W-1:0]   sram_kb,
  input logic              inv_valid,
  input logic              inv_global,
  input logic [LINE_W-1:0] inv_line
);
  localparam int MAX_CODE = $clog2(TOTAL_KB / MIN_KB) + 1;

  logic size_chg, glob_wr, cnt_wr;
  assign size_chg = cfg_wr_en && cfg_addr == 3'd0 && int'(cfg_wdata[2:0]) <= MAX_CODE
                    && cfg_wdata[2:0] != cfg_rdata[2:0];
  assign glob_wr  = cfg_wr_en && cfg_addr == 3'd2 && cfg_wdata[0];
  assign cnt_wr   = cfg_wr_en && cfg_addr == 3'd4;

  assert_kb_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cache_kb) + 32'(sram_kb)) == TOTAL_KB);

  assert_kb_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cache_kb) && int'(cache_kb) <= TOTAL_KB && (cache_kb == '0 || int'(cache_kb) >= MIN_KB));

  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr == 3'd0 && int'(cfg_wdata[2:0]) > MAX_CODE) |=> $stable(cache_kb));

  assert_size_sweep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    size_chg |=> (inv_valid && inv_global && inv_line == '0));

  assert_glob_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    glob_wr |=> (inv_valid && inv_global && inv_line == '0));

  assert_glob_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_global && inv_line != LINE_W'((TOTAL_KB * 1024 / 32) - 1) && !size_chg && !glob_wr)
    |=> (inv_valid && inv_global && inv_line == LINE_W'($past(inv_line) + 1'b1)));

  assert_blk_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_global && !size_chg && !glob_wr)
    |=> (!inv_valid || (!inv_global && inv_line == LINE_W'($past(inv_line) + 1'b1))));

  assert_cnt_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && inv_valid && inv_global && !glob_wr) |=> (inv_valid && inv_global));

endmodule

bind icache_cfg_regs icache_cfg_checker #(
  .TOTAL_KB(TOTAL_KB), .MIN_KB(MIN_KB),
  .KB_W($clog2(TOTAL_KB+1)), .LINE_W(ADDR_W-$clog2(LINE_BYTES))
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cache_kb(cache_kb),
  .sram_kb(sram_kb), .inv_valid(inv_valid), .inv_global(inv_global),
  .inv_line(inv_line)
);

// File: tb/icache_cfg_regs_tb.sv
module icache_cfg_regs_tb;
  localparam int LINE_W = 27;
  localparam int SETS   = 1024;
  localparam time TCLK  = 8ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [31:0]       cfg_rdata;
  logic [5:0]        cache_kb, sram_kb;
  logic              freeze_en, inv_valid, inv_global;
  logic [LINE_W-1:0] inv_line;

  int total = 0;
  int bad   = 0;
  int model_code = 0;
  logic [31:0] rv;

  always #(TCLK/2) clk = ~clk;

  icache_cfg_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cache_kb(cache_kb),
    .sram_kb(sram_kb), .freeze_en(freeze_en), .inv_valid(inv_valid),
    .inv_global(inv_global), .inv_line(inv_line)
  );

  function automatic int kb_of(input int code);
    return (code == 0) ? 0 : (4 << (code - 1));
  endfunction

  function automatic int first_line(input int base);
    return base / 32;
  endfunction

  function automatic int last_line(input int base, input int cnt);
    return (base + 4 * cnt - 1) / 32;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1;
    v = cfg_rdata;
  endtask

  task automatic expect_walk(input string req, input bit glob, input int first, input int last);
    int miss = 0;
    for (int i = first; i <= last; i++) begin
      if (!(inv_valid === 1'b1 && inv_global === glob && inv_line === LINE_W'(i))) miss++;
      @(negedge clk);
    end
    check(req, miss, 0);
    check(req, 32'(inv_valid), 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && inv_valid === 1'b1; i++) @(negedge clk);
  endtask

  task automatic check_size(input string req);
    check(req, 32'(cache_kb), kb_of(model_code));
    check(req, 32'(sram_kb), 32 - kb_of(model_code));
  endtask

  initial begin
    #(TCLK * 190000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1CC5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 cache_kb", 32'(cache_kb), 0);
    check("R1 sram_kb", 32'(sram_kb), 32);
    check("R1 freeze", 32'(freeze_en), 0);
    check("R1 inv_valid", 32'(inv_valid), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      check("R1 reg reset", rv, 0);
    end

    // R10 unmapped offsets
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), rv);
      check("R10 unmapped read", rv, 0);
    end

    // R4 freeze
    wr(3'd1, 32'h1);
    check("R4 freeze on", 32'(freeze_en), 1);
    rd(3'd1, rv);
    check("R4 freeze readback", rv, 1);
    wr(3'd1, 32'hFFFF_FFFE);
    check("R4 freeze off", 32'(freeze_en), 0);

    // R2/R5 directed: size change to 4 KB sweeps full index range
    wr(3'd0, 32'd1);
    model_code = 1;
    check_size("R2 4KB");
    expect_walk("R5 size sweep", 1'b1, 0, SETS - 1);
    rd(3'd0, rv);
    check("R2 size readback", rv, 1);
    // same code again: no sweep
    wr(3'd0, 32'd1);
    check("R5 same code no sweep", 32'(inv_valid), 0);
    // reserved code
    wr(3'd0, 32'd6);
    check("R3 reserved no sweep", 32'(inv_valid), 0);
    check_size("R3 reserved ignored");
    rd(3'd0, rv);
    check("R3 size reg kept", rv, 1);

    // R6 global trigger and status reads
    wr(3'd2, 32'h1);
    expect_walk("R6 global sweep", 1'b1, 0, SETS - 1);
    rd(3'd2, rv);
    check("R6 status after sweep", rv, 0);
    wr(3'd2, 32'h1);
    rd(3'd2, rv);
    check("R6 status during sweep", rv, 3);
    wait_idle();
    wr(3'd2, 32'h2);
    check("R6 bit0 clear no sweep", 32'(inv_valid), 0);

    // R7 block walks
    wr(3'd3, 32'h100);
    wr(3'd4, 32'd8);
    expect_walk("R7 one line", 1'b0, 8, 8);
    wr(3'd3, 32'h104);
    wr(3'd4, 32'd8);
    expect_walk("R7 crosses line", 1'b0, 8, 9);
    wr(3'd4, 32'd0);
    check("R7 zero count", 32'(inv_valid), 0);
    wr(3'd3, 32'h40);
    wr(3'd4, 32'd40);
    rd(3'd2, rv);
    check("R7 status during walk", rv, 2);
    wait_idle();

    // R8 global supersedes block walk
    wr(3'd3, 32'h0);
    wr(3'd4, 32'd400);
    check("R8 walk started", 32'(inv_line), 0);
    wr(3'd2, 32'h1);
    expect_walk("R8 abandon walk", 1'b1, 0, SETS - 1);
    // R8 restart of sweep by size change
    wr(3'd2, 32'h1);
    repeat (5) @(negedge clk);
    wr(3'd0, 32'd3);
    model_code = 3;
    expect_walk("R8 restart sweep", 1'b1, 0, SETS - 1);
    check_size("R2 16KB");

    // R9 count write while busy
    wr(3'd2, 32'h1);
    wr(3'd4, 32'd7);
    wr(3'd3, 32'h2000);
    wait_idle();
    @(negedge clk);
    check("R9 no walk after busy", 32'(inv_valid), 0);
    rd(3'd4, rv);
    check("R9 count kept", rv, 400);
    rd(3'd3, rv);
    check("R9 base accepted", rv, 32'h2000);

    // R2/R3/R5 random sizes
    for (int n = 0; n < 24; n++) begin
      int code;
      int prev;
      code = int'($urandom % 8);
      prev = model_code;
      wr(3'd0, 32'(code));
      if (code <= 4) model_code = code;
      if (model_code != prev) begin
        check("R5 random change sweep", {inv_valid, inv_global, 5'(inv_line)}, {2'b11, 5'd0});
        wait_idle();
      end else begin
        check("R3 R5 random no sweep", 32'(inv_valid), 0);
      end
      check_size("R2 random size");
    end

    // R7 random block walks
    for (int n = 0; n < 16; n++) begin
      int base;
      int cnt;
      base = int'($urandom % 4096);
      cnt  = 1 + int'($urandom % 64);
      wr(3'd3, 32'(base));
      wr(3'd4, 32'(cnt));
      expect_walk("R7 random walk", 1'b0, first_line(base), last_line(base, cnt));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule